// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block holds the tag state of an N-way set-associative cache and no data. Each request is a load or a store carrying a 32-bit physical address. The address is cut into an offset field (lowest bits), a set index (the bits just above the offset) and a tag (everything above both). All ways of the chosen set are compared at once. The controller reports a hit, a cold miss or a conflict miss, and it keeps per-way valid and dirty bits. On a miss it fills the lowest-numbered free way. When the set is full it replaces a victim. The victim comes from a tree pseudo-LRU or from a pseudo-random generator, and the choice is made at run time.

Eight event counters run beside the tag state, together with a miss-penalty accumulator. A line fetch from memory costs 100 cycles for each word of the line. A small state machine sequences the response. In state `ST_IDLE` no response is presented. A request in any cycle moves it to `ST_RESP`, so the response is valid in the following cycle. It stays in `ST_RESP` while requests keep arriving back to back, and it returns to `ST_IDLE` after a cycle with no request. The way count, index width, offset width and words per line are parameters.

Top module: `cache_tag_ctl`

## Requirements
- R1: The index is `req_addr[OFF_W+IDX_W-1:OFF_W]` and the tag is `req_addr[31:OFF_W+IDX_W]`. The offset bits `req_addr[OFF_W-1:0]` never affect the outcome. Requests with equal tag and index hit the same entry, and requests with equal index but different tags compete for the same set.
- R2: A request hits only if some way of its set is valid and holds an equal tag. Then `rsp_hit`=1 and `rsp_way` gives that way.
- R3: A store hit sets the dirty bit of the hit way. A load hit leaves that bit as it was. `rsp_dirty` reports the way's dirty bit after the access.
- R4: A miss in a set with at least one invalid way is a cold miss (`rsp_cold`=1). The tag goes into the lowest-numbered invalid way, which becomes valid with its dirty bit clear.
- R5: A miss in a set whose ways are all valid is a conflict miss (`rsp_conflict`=1). The victim way is overwritten with the new tag, and its dirty bit becomes 1 for a store and 0 for a load.
- R6: With `policy_rand`=0 the victim comes from a per-set tree of WAYS-1 bits. At each node, 0 means descend left (toward lower ways) and 1 means descend right. Every access (hit or fill) to way w sets each node on w's path to point away from w.
- R7: With `policy_rand`=1 the victim is the low bits of a free-running LFSR, so any way may be chosen. Hits and fills still update the tree of R6.
- R8: The response to a request sampled at a rising edge is presented after that edge, with `rsp_valid`=1. Exactly one of `rsp_hit`, `rsp_cold` and `rsp_conflict` is 1. After a cycle with no request `rsp_valid`=0.
- R9: Counters track loads, stores, load hits, store hits, load misses, store misses, cold misses and conflict misses. Each advances by one for every request of its kind.
- R10: `penalty_total` grows by 100*LINE_WORDS on every load cold miss and every conflict miss. On a store cold miss it grows only when `write_through`=1. Hits add nothing.
- R11: After reset every way is invalid and clean, every tree bit is 0, and all counters and the penalty are zero.
- R12: A cycle with `req_valid`=0 changes no tag state, counter or penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Physical address |
| policy_rand | input | 1 | 0 = tree pseudo-LRU, 1 = random victim |
| write_through | input | 1 | Store cold misses fetch (add penalty) when 1 |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request hit |
| rsp_cold | output | 1 | Miss filled a free way |
| rsp_conflict | output | 1 | Miss replaced a victim |
| rsp_way | output | $clog2(WAYS) | Way that was hit or filled |
| rsp_dirty | output | 1 | Dirty bit of that way after the access |
| cnt_load | output | CNT_W | Loads seen |
| cnt_store | output | CNT_W | Stores seen |
| cnt_load_hit | output | CNT_W | Load hits |
| cnt_store_hit | output | CNT_W | Store hits |
| cnt_load_miss | output | CNT_W | Load misses |
| cnt_store_miss | output | CNT_W | Store misses |
| cnt_cold | output | CNT_W | Cold misses |
| cnt_conflict | output | CNT_W | Conflict misses |
| penalty_total | output | PEN_W | Accumulated miss-penalty cycles |

## Verification
The bound checker verifies on every cycle the properties that hold whatever the tag contents are:
- a response follows each request by one cycle, with exactly one outcome;
- the dirty flag agrees with the request kind on store hits, cold fills and conflict fills;
- the counters stay balanced (load hits plus load misses equal loads, and the two miss classes sum to all misses);
- conflict misses add one line's penalty, hits add none;
- idle cycles leave the counters and the penalty unchanged.

Which way is hit, which free way is filled, which tree victim is chosen, and whether a store cold miss is charged under each write mode depend on the stored history. Only the bench's reference model can check these: it keeps its own copy of every set and tree and compares all outputs on every clock.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_t;

    localparam int MISS_CYC_PER_WORD = 100;

    localparam int NUM_EV      = 8;
    localparam int EV_LOAD     = 0;
    localparam int EV_STORE    = 1;
    localparam int EV_LD_HIT   = 2;
    localparam int EV_ST_HIT   = 3;
    localparam int EV_LD_MISS  = 4;
    localparam int EV_ST_MISS  = 5;
    localparam int EV_COLD     = 6;
    localparam int EV_CONFLICT = 7;

endpackage

// File: rtl/plru_tree.sv
module plru_tree #(
    parameter int WAYS = 4,
    localparam int WW = $clog2(WAYS)
) (
    input  logic [WAYS-2:0] bits_i,
    input  logic [WW-1:0]   touch_way_i,
    output logic [WW-1:0]   victim_o,
    output logic [WAYS-2:0] bits_o
);

    // Node n (1-based heap numbering) lives at bit n-1.
    // A node bit of 0 leads the victim search to the left child.
    always_comb begin
        int node;
        node = 1;
        for (int l = 0; l < WW; l++) begin
            node = 2 * node + int'(bits_i[node-1]);
        end
        victim_o = WW'(node - WAYS);
    end

    always_comb begin
        int node;
        bits_o = bits_i;
        node = 1;
        for (int l = WW - 1; l >= 0; l--) begin
            bits_o[node-1] = ~touch_way_i[l];
            node = 2 * node + int'(touch_way_i[l]);
        end
    end

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
    parameter int          W     = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'h0001,
    parameter int          OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);

    logic [W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED[W-1:0];
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS[W-1:0];
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign rnd_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/event_counters.sv
module event_counters #(
    parameter int NEV   = 8,
    parameter int CNT_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NEV-1:0]            inc_i,
    output logic [NEV-1:0][CNT_W-1:0] cnt_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else begin
            for (int e = 0; e < NEV; e++) begin
                if (inc_i[e]) cnt_o[e] <= cnt_o[e] + 1'b1;
            end
        end
    end

endmodule

// File: rtl/cache_tag_ctl.sv
module cache_tag_ctl
    import cache_tag_pkg::*;
#(
    parameter int WAYS       = 4,
    parameter int IDX_W      = 4,
    parameter int OFF_W      = 4,
    parameter int LINE_WORDS = 4,
    parameter int CNT_W      = 32,
    parameter int PEN_W      = 32,
    localparam int WW        = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_store,
    input  logic [31:0]      req_addr,
    input  logic             policy_rand,
    input  logic             write_through,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_cold,
    output logic             rsp_conflict,
    output logic [WW-1:0]    rsp_way,
    output logic             rsp_dirty,
    output logic [CNT_W-1:0] cnt_load,
    output logic [CNT_W-1:0] cnt_store,
    output logic [CNT_W-1:0] cnt_load_hit,
    output logic [CNT_W-1:0] cnt_store_hit,
    output logic [CNT_W-1:0] cnt_load_miss,
    output logic [CNT_W-1:0] cnt_store_miss,
    output logic [CNT_W-1:0] cnt_cold,
    output logic [CNT_W-1:0] cnt_conflict,
    output logic [PEN_W-1:0] penalty_total
);

    localparam int SETS    = 1 << IDX_W;
    localparam int TAG_LSB = OFF_W + IDX_W;
    localparam int TAG_W   = 32 - TAG_LSB;
    localparam int PENALTY = MISS_CYC_PER_WORD * LINE_WORDS;

    // ---------------- tag state ----------------
    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAYS-2:0]  plru_q  [SETS];

    // ---------------- address split ----------------
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic             unused_offset;

    assign idx           = req_addr[TAG_LSB-1:OFF_W];
    assign tag           = req_addr[31:TAG_LSB];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    // ---------------- parallel compare ----------------
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[idx][w] && (tag_q[idx][w] == tag);
    end

    logic [WW-1:0] hit_way, free_way;

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])        hit_way  = WW'(w);
            if (!valid_q[idx][w])  free_way = WW'(w);
        end
    end

    logic is_hit, is_cold, is_conflict;

    assign is_hit      = |hit_vec;
    assign is_cold     = !is_hit && !(&valid_q[idx]);
    assign is_conflict = !is_hit &&  (&valid_q[idx]);

    // ---------------- victim selection ----------------
    logic [WW-1:0]   plru_victim, rand_victim, victim, tgt_way;
    logic [WAYS-2:0] plru_next;

    plru_tree #(.WAYS(WAYS)) u_plru (
        .bits_i      (plru_q[idx]),
        .touch_way_i (tgt_way),
        .victim_o    (plru_victim),
        .bits_o      (plru_next)
    );

    lfsr_gen #(.W(16), .TAPS(16'hB400), .SEED(16'h0001), .OUT_W(WW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rand_victim)
    );

    assign victim  = policy_rand ? rand_victim : plru_victim;
    assign tgt_way = is_hit ? hit_way : (is_cold ? free_way : victim);

    logic new_dirty, fetch;

    assign new_dirty = is_hit ? (dirty_q[idx][tgt_way] | req_store)
                              : (is_conflict & req_store);
    assign fetch     = is_conflict | (is_cold & (!req_store | write_through));

    // ---------------- state machine ----------------
    ctl_state_t state_q, state_nx;

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: rsp_valid = 1'b0;
            ST_RESP: rsp_valid = 1'b1;
            default: rsp_valid = 1'b0;
        endcase
    end

    // ---------------- response and table update ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit       <= 1'b0;
            rsp_cold      <= 1'b0;
            rsp_conflict  <= 1'b0;
            rsp_way       <= '0;
            rsp_dirty     <= 1'b0;
            penalty_total <= '0;
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                plru_q[s]  <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else if (req_valid) begin
            rsp_hit               <= is_hit;
            rsp_cold              <= is_cold;
            rsp_conflict          <= is_conflict;
            rsp_way               <= tgt_way;
            rsp_dirty             <= new_dirty;
            tag_q[idx][tgt_way]   <= tag;
            valid_q[idx][tgt_way] <= 1'b1;
            dirty_q[idx][tgt_way] <= new_dirty;
            plru_q[idx]           <= plru_next;
            if (fetch) penalty_total <= penalty_total + PEN_W'(PENALTY);
        end
    end

    // ---------------- event counters ----------------
    logic [NUM_EV-1:0]             ev_inc;
    logic [NUM_EV-1:0][CNT_W-1:0]  ev_cnt;

    always_comb begin
        ev_inc = '0;
        if (req_valid) begin
            ev_inc[EV_LOAD]     = !req_store;
            ev_inc[EV_STORE]    =  req_store;
            ev_inc[EV_LD_HIT]   = !req_store &&  is_hit;
            ev_inc[EV_ST_HIT]   =  req_store &&  is_hit;
            ev_inc[EV_LD_MISS]  = !req_store && !is_hit;
            ev_inc[EV_ST_MISS]  =  req_store && !is_hit;
            ev_inc[EV_COLD]     = is_cold;
            ev_inc[EV_CONFLICT] = is_conflict;
        end
    end

    event_counters #(.NEV(NUM_EV), .CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (ev_inc),
        .cnt_o (ev_cnt)
    );

    assign cnt_load       = ev_cnt[EV_LOAD];
    assign cnt_store      = ev_cnt[EV_STORE];
    assign cnt_load_hit   = ev_cnt[EV_LD_HIT];
    assign cnt_store_hit  = ev_cnt[EV_ST_HIT];
    assign cnt_load_miss  = ev_cnt[EV_LD_MISS];
    assign cnt_store_miss = ev_cnt[EV_ST_MISS];
    assign cnt_cold       = ev_cnt[EV_COLD];
    assign cnt_conflict   = ev_cnt[EV_CONFLICT];

endmodule

// File: rtl/cache_tag_ctl_chk.sv
module cache_tag_ctl_chk #(
    parameter int CNT_W   = 32,
    parameter int PEN_W   = 32,
    parameter int PENALTY = 400
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_store,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_cold,
    input logic             rsp_conflict,
    input logic             rsp_dirty,
    input logic [CNT_W-1:0] cnt_load,
    input logic [CNT_W-1:0] cnt_store,
    input logic [CNT_W-1:0] cnt_load_hit,
    input logic [CNT_W-1:0] cnt_load_miss,
    input logic [CNT_W-1:0] cnt_store_miss,
    input logic [CNT_W-1:0] cnt_cold,
    input logic [CNT_W-1:0] cnt_conflict,
    input logic [PEN_W-1:0] penalty_total
);

    logic [CNT_W-1:0] ld_sum, miss_sum, class_sum;

    assign ld_sum    = cnt_load_hit + cnt_load_miss;
    assign miss_sum  = cnt_load_miss + cnt_store_miss;
    assign class_sum = cnt_cold + cnt_conflict;

    assert_resp_after_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_resp_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_single_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_hit, rsp_cold, rsp_conflict}) == 1));

    assert_store_hit_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit && $past(req_store)) |-> rsp_dirty);

    assert_cold_fill_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cold) |-> !rsp_dirty);

    assert_conflict_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_conflict) |-> (rsp_dirty == $past(req_store)));

    assert_load_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sum == cnt_load);

    assert_miss_balance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_sum == class_sum);

    assert_conflict_penalty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_conflict) |-> (penalty_total == $past(penalty_total) + PEN_W'(PENALTY)));

    assert_hit_no_penalty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> $stable(penalty_total));

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(cnt_load) && $stable(cnt_store) && $stable(penalty_total)));

endmodule

bind cache_tag_ctl cache_tag_ctl_chk #(
    .CNT_W   (CNT_W),
    .PEN_W   (PEN_W),
    .PENALTY (PENALTY)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_store      (req_store),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_cold       (rsp_cold),
    .rsp_conflict   (rsp_conflict),
    .rsp_dirty      (rsp_dirty),
    .cnt_load       (cnt_load),
    .cnt_store      (cnt_store),
    .cnt_load_hit   (cnt_load_hit),
    .cnt_load_miss  (cnt_load_miss),
    .cnt_store_miss (cnt_store_miss),
    .cnt_cold       (cnt_cold),
    .cnt_conflict   (cnt_conflict),
    .penalty_total  (penalty_total)
);

// File: tb/tb_cache_tag_ctl.sv
module tb_cache_tag_ctl;

    localparam int CLK_PERIOD = 10;
    localparam int WAYS       = 4;
    localparam int IDX_W      = 4;
    localparam int OFF_W      = 4;
    localparam int LINE_WORDS = 4;
    localparam int SETS       = 16;
    localparam int PEN        = 100 * LINE_WORDS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [31:0] req_addr = '0;
    logic        policy_rand = 1'b0;
    logic        write_through = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_cold, rsp_conflict, rsp_dirty;
    logic [1:0]  rsp_way;
    logic [31:0] cnt_load, cnt_store, cnt_load_hit, cnt_store_hit;
    logic [31:0] cnt_load_miss, cnt_store_miss, cnt_cold, cnt_conflict;
    logic [31:0] penalty_total;

    cache_tag_ctl #(
        .WAYS(WAYS), .IDX_W(IDX_W), .OFF_W(OFF_W), .LINE_WORDS(LINE_WORDS),
        .CNT_W(32), .PEN_W(32)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .policy_rand(policy_rand), .write_through(write_through),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_cold(rsp_cold),
        .rsp_conflict(rsp_conflict), .rsp_way(rsp_way), .rsp_dirty(rsp_dirty),
        .cnt_load(cnt_load), .cnt_store(cnt_store), .cnt_load_hit(cnt_load_hit),
        .cnt_store_hit(cnt_store_hit), .cnt_load_miss(cnt_load_miss),
        .cnt_store_miss(cnt_store_miss), .cnt_cold(cnt_cold),
        .cnt_conflict(cnt_conflict), .penalty_total(penalty_total)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model ----------------
    int unsigned m_tag  [SETS][WAYS];
    bit          m_val  [SETS][WAYS];
    bit          m_dir  [SETS][WAYS];
    bit          m_tree [SETS][WAYS];   // nodes 1..WAYS-1

    bit          e_valid, e_hit, e_cold, e_conf, e_dirty, e_way_known;
    int          e_way;
    string       e_label;
    int unsigned e_cnt [8];
    int unsigned e_pen;

    bit          pend_rand;
    int          pend_set;
    int unsigned pend_tag;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    function automatic int tree_pick(int s);
        int lo = 0;
        int hi = WAYS;
        int node = 1;
        while (hi - lo > 1) begin
            int mid = (lo + hi) / 2;
            if (!m_tree[s][node]) begin hi = mid; node = 2 * node; end
            else                  begin lo = mid; node = 2 * node + 1; end
        end
        return lo;
    endfunction

    task automatic tree_touch(int s, int w);
        int lo = 0;
        int hi = WAYS;
        int node = 1;
        while (hi - lo > 1) begin
            int mid = (lo + hi) / 2;
            if (w < mid) begin m_tree[s][node] = 1'b1; hi = mid; node = 2 * node; end
            else         begin m_tree[s][node] = 1'b0; lo = mid; node = 2 * node + 1; end
        end
    endtask

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(e_label, "rsp_valid", rsp_valid, e_valid);
        if (e_valid) begin
            chk(e_label, "rsp_hit", rsp_hit, e_hit);
            chk(e_label, "rsp_cold", rsp_cold, e_cold);
            chk(e_label, "rsp_conflict", rsp_conflict, e_conf);
            chk(e_label, "rsp_dirty", rsp_dirty, e_dirty);
            if (e_way_known) chk(e_label, "rsp_way", rsp_way, e_way);
        end
        if (pend_rand) begin
            int w = int'(rsp_way);
            m_tag[pend_set][w] = pend_tag;
            m_val[pend_set][w] = 1'b1;
            m_dir[pend_set][w] = e_dirty;
            tree_touch(pend_set, w);
            pend_rand = 1'b0;
        end
        chk("R9", "cnt_load", cnt_load, e_cnt[0]);
        chk("R9", "cnt_store", cnt_store, e_cnt[1]);
        chk("R9", "cnt_load_hit", cnt_load_hit, e_cnt[2]);
        chk("R9", "cnt_store_hit", cnt_store_hit, e_cnt[3]);
        chk("R9", "cnt_load_miss", cnt_load_miss, e_cnt[4]);
        chk("R9", "cnt_store_miss", cnt_store_miss, e_cnt[5]);
        chk("R9", "cnt_cold", cnt_cold, e_cnt[6]);
        chk("R9", "cnt_conflict", cnt_conflict, e_cnt[7]);
        chk("R10", "penalty_total", penalty_total, e_pen);
    endtask

    task automatic model_req(bit st, logic [31:0] a, bit pol, bit wt, string label);
        int s = int'(a[OFF_W +: IDX_W]);
        int unsigned t = int'(a >> (OFF_W + IDX_W));
        int w = -1;
        e_label = label;
        e_valid = 1'b1;
        e_hit = 0; e_cold = 0; e_conf = 0; e_way_known = 1'b1;
        for (int i = 0; i < WAYS; i++)
            if (w < 0 && m_val[s][i] && m_tag[s][i] == t) w = i;
        if (st) e_cnt[1]++; else e_cnt[0]++;
        if (w >= 0) begin
            e_hit = 1'b1;
            if (st) m_dir[s][w] = 1'b1;
            e_dirty = m_dir[s][w];
            e_way = w;
            tree_touch(s, w);
            if (st) e_cnt[3]++; else e_cnt[2]++;
        end else begin
            if (st) e_cnt[5]++; else e_cnt[4]++;
            for (int i = 0; i < WAYS; i++)
                if (w < 0 && !m_val[s][i]) w = i;
            if (w >= 0) begin
                e_cold = 1'b1;
                e_cnt[6]++;
                m_tag[s][w] = t; m_val[s][w] = 1'b1; m_dir[s][w] = 1'b0;
                e_dirty = 1'b0;
                e_way = w;
                tree_touch(s, w);
                if (!st || wt) e_pen += PEN;
            end else begin
                e_conf = 1'b1;
                e_cnt[7]++;
                e_pen += PEN;
                e_dirty = st;
                if (!pol) begin
                    w = tree_pick(s);
                    m_tag[s][w] = t; m_val[s][w] = 1'b1; m_dir[s][w] = st;
                    e_way = w;
                    tree_touch(s, w);
                end else begin
                    e_way_known = 1'b0;
                    pend_rand = 1'b1;
                    pend_set = s;
                    pend_tag = t;
                end
            end
        end
    endtask

    task automatic cyc(bit v, bit st, logic [31:0] a, bit pol, bit wt, string label);
        @(negedge clk);
        compare();
        req_valid = v; req_store = st; req_addr = a;
        policy_rand = pol; write_through = wt;
        if (v) model_req(st, a, pol, wt, label);
        else begin e_valid = 1'b0; e_label = "R12"; end
    endtask

    function automatic logic [31:0] mk(int unsigned t, int s, int off);
        return (32'(t) << (OFF_W + IDX_W)) | (32'(s) << OFF_W) | 32'(off);
    endfunction

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_tag[s][w] = 0; m_val[s][w] = 0; m_dir[s][w] = 0; m_tree[s][w] = 0;
            end
        for (int i = 0; i < 8; i++) e_cnt[i] = 0;
        e_pen = 0; e_valid = 0; e_label = "R11"; pend_rand = 0; e_way_known = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state, then idle cycles (R12)
        cyc(0, 0, '0, 0, 0, "R12");
        cyc(0, 0, '0, 0, 0, "R12");

        // R4: four cold load misses fill ways 0..3 in set 3
        for (int i = 0; i < 4; i++) cyc(1, 0, mk(32'h10 + i, 3, 0), 0, 0, "R4");
        // R2/R1: hits on each, offset varies; high tag bit distinguishes
        for (int i = 0; i < 4; i++) cyc(1, 0, mk(32'h10 + i, 3, i * 3), 0, 0, "R1");
        cyc(1, 0, mk(32'h80000 | 32'h10, 3, 0) & 32'hFFFF_FFFF, 0, 0, "R2");
        // R3: store hit sets dirty, later load hit keeps it
        cyc(1, 1, mk(32'h12, 3, 4), 0, 0, "R3");
        cyc(1, 0, mk(32'h12, 3, 8), 0, 0, "R3");
        cyc(0, 0, '0, 0, 0, "R12");
        // R6: tree-based conflicts in set 3
        for (int i = 0; i < 6; i++) cyc(1, i % 2, mk(32'h40 + i, 3, 0), 0, 0, "R6");
        // R10: store cold misses with and without write-through
        cyc(1, 1, mk(32'h5, 7, 0), 0, 0, "R10");
        cyc(1, 1, mk(32'h6, 7, 0), 0, 1, "R10");
        cyc(1, 0, mk(32'h7, 7, 0), 0, 0, "R10");
        cyc(1, 1, mk(32'h8, 7, 0), 0, 1, "R10");
        // R5: conflict store and load in full set 7
        cyc(1, 1, mk(32'h9, 7, 0), 0, 0, "R5");
        cyc(1, 0, mk(32'hA, 7, 0), 0, 0, "R5");
        // R7: random victims
        for (int i = 0; i < 12; i++) cyc(1, i % 3 == 0, mk(32'h100 + i, 7, 0), 1, 0, "R7");
        cyc(0, 0, '0, 0, 0, "R12");

        // mixed traffic, R8 response timing under gaps and bursts
        for (int n = 0; n < 3000; n++) begin
            bit v   = ($urandom % 4) != 0;
            bit st  = $urandom % 2;
            bit pol = ($urandom % 3) == 0;
            bit wt  = $urandom % 2;
            cyc(v, st, mk($urandom % 7, $urandom % 4, $urandom % 16), pol, wt, "R8");
        end
        cyc(0, 0, '0, 0, 0, "R12");
        cyc(0, 0, '0, 0, 0, "R12");
        finished = 1'b1;
        finish_run();
    end

endmodule